// File: doc/BRIEF.md
# DMA Transfer Address Generator

This block holds the working state of a set of DMA channels and turns each channel's programmed page number, 16-bit start address and 16-bit transfer count into 24-bit physical bus addresses. A channel runs in one of two widths. A byte channel steps through bytes inside a 64 KB page. A word channel steps through 16-bit words inside a 128 KB page, and it can never produce an odd byte address.

Software sets up the base values and then pulses the channel's load line. This copies the base values into the current address and count and unmasks the channel. An external arbiter pulses the transfer strobe once for each acknowledged bus cycle. The channel then moves to the next address and counts down. The transfer that runs the count below zero raises terminal count. The channel then either reloads itself from its base values (auto-initialise) or masks itself. The address counter never carries into the page, so a transfer wraps inside its page.

Top module: `xfer_addr_gen`

## Requirements
- R1: On a byte channel (word select 0) the physical address is {page[7:0], current address[15:0]}. The lane enable is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1.
- R2: On a word channel (word select 1) the physical address is {page[7:1], current address[15:0], 1'b0}. Page bit 0 has no effect, and the lane enable is 2'b11.
- R3: A transfer strobe on an unmasked channel, with no load in the same cycle, increments the current address by one. It also decrements the current count by one. The new address shows on the physical address output after that clock edge.
- R4: After a load with base count N-1, exactly N accepted strobes occur before terminal count. Terminal count comes on the N-th strobe.
- R5: Terminal count is a one-cycle pulse. It is high in the cycle after the clock edge that accepted a strobe while the current count was 0x0000.
- R6: With auto-initialise set, the terminal-count transfer reloads the current address and count from the base values. The channel stays unmasked.
- R7: With auto-initialise clear, the terminal-count transfer masks the channel. Later strobes leave the physical address unchanged.
- R8: While a channel is masked, by reset, by its mask-set input or by R7, strobes leave its address and count unchanged. A mask-clear pulse unmasks it.
- R9: A load pulse copies the base address and base count into the current registers and unmasks the channel. Load takes priority over a strobe in the same cycle.
- R10: After reset every channel is masked, every current address is 0 and no terminal count is raised.
- R11: An increment past address 0xFFFF wraps to 0x0000 without changing the page bits of the physical address, on both byte and word channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_load | input | NCH | Per-channel pulse: copy base values to current and unmask |
| ch_page | input | NCH*8 | Per-channel page number |
| ch_base_addr | input | NCH*16 | Per-channel base (start) address |
| ch_base_cnt | input | NCH*16 | Per-channel base count (transfers minus one) |
| ch_autoinit | input | NCH | Per-channel auto-initialise mode bit |
| ch_word | input | NCH | Per-channel width select: 1 word, 0 byte |
| ch_mask_set | input | NCH | Per-channel pulse: mask the channel |
| ch_mask_clr | input | NCH | Per-channel pulse: unmask the channel |
| ch_xfer | input | NCH | Per-channel acknowledged-transfer strobe |
| phys_addr | output | NCH*24 | Per-channel physical address of the next transfer |
| lane_en | output | NCH*2 | Per-channel byte-lane enables (2'b11 for word) |
| tc_pulse | output | NCH | Per-channel terminal-count pulse |

## Verification
The in-RTL properties check four things on every cycle: an accepted strobe steps the address by one modulo 64K, a masked channel holds its address, terminal count appears only after a strobe that found the count at zero, and that transfer either reloads the base values or leaves the channel masked. The bench scenarios are the only place that shows the end-to-end results. These are the address-bit mapping for each width, including the ignored page bit 0, the exact count of N transfers from a loaded N-1, and the wrap at 0xFFFF that leaves the page unchanged. They also include the reset state and the order of mask-set, mask-clear and load.

// File: rtl/xag_pkg.sv
package xag_pkg;

   // Lane-enable code for one transfer: both lanes for a word,
   // otherwise the lane picked by the low address bit.
   function automatic logic [1:0] lane_code(input logic is_word, input logic a0);
      if (is_word) lane_code = 2'b11;
      else if (a0) lane_code = 2'b10;
      else         lane_code = 2'b01;
   endfunction

endpackage

// File: rtl/xag_counter.sv
module xag_counter #(
   parameter int ADDR_W      = 16,
   parameter int CNT_W       = 16,
   parameter bit AUTOINIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              xfer,
   input  logic              mask_set,
   input  logic              mask_clr,
   input  logic              autoinit,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [CNT_W-1:0]  base_cnt,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              tc
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("xag_counter: ADDR_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("xag_counter: CNT_W must be at least 1");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              mask_q;
   logic              tc_q;
   logic              auto_eff;
   logic              accept;
   logic              last;

   if (AUTOINIT_EN) begin : g_auto
      assign auto_eff = autoinit;
   end else begin : g_noauto
      assign auto_eff = 1'b0;
   end

   assign accept = xfer && !mask_q && !load;
   assign last   = accept && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         mask_q <= 1'b1;
         tc_q   <= 1'b0;
      end else begin
         tc_q <= last;
         if (load || (last && auto_eff)) begin
            addr_q <= base_addr;
            cnt_q  <= base_cnt;
         end else if (accept) begin
            addr_q <= addr_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
         end
         if (mask_set)                 mask_q <= 1'b1;
         else if (load)                mask_q <= 1'b0;
         else if (last && !auto_eff)   mask_q <= 1'b1;
         else if (mask_clr)            mask_q <= 1'b0;
      end
   end

   assign cur_addr = addr_q;
   assign tc       = tc_q;

   // R3 / R11: an accepted, non-final strobe steps the address modulo 2^ADDR_W
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !mask_q && !load && cnt_q != '0)
      |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

   // R8: a masked channel without load keeps its address
   p_masked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && !load) |=> (addr_q == $past(addr_q)));

   // R5: terminal count follows only a strobe that found the count at zero
   p_tc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tc_q |-> $past(xfer && !mask_q && !load && cnt_q == '0));

   // R6: auto-initialise reloads both current registers at terminal count
   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !mask_q && !load && cnt_q == '0 && auto_eff)
      |=> (addr_q == $past(base_addr) && cnt_q == $past(base_cnt)));

   // R7: without auto-initialise the channel ends masked
   p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !mask_q && !load && cnt_q == '0 && !auto_eff) |=> mask_q);

endmodule

// File: rtl/xag_map.sv
module xag_map
   import xag_pkg::*;
#(
   parameter int  PAGE_W  = 8,
   parameter int  ADDR_W  = 16,
   parameter bit  WORD_EN = 1'b1,
   localparam int PHYS_W  = PAGE_W + ADDR_W
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [ADDR_W-1:0] addr,
   input  logic              word,
   output logic [PHYS_W-1:0] phys,
   output logic [1:0]        lanes
);

   if (PAGE_W < 2) begin : g_bad_page
      $error("xag_map: PAGE_W must be at least 2");
   end

   if (WORD_EN) begin : g_dual
      always_comb begin
         if (word) phys = {page[PAGE_W-1:1], addr, 1'b0};
         else      phys = {page, addr};
         lanes = lane_code(word, addr[0]);
      end
   end else begin : g_byte_only
      logic unused_word;
      assign unused_word = word;
      always_comb begin
         phys  = {page, addr};
         lanes = lane_code(1'b0, addr[0]);
      end
   end

endmodule

// File: rtl/xag_chan.sv
module xag_chan #(
   parameter int  PAGE_W      = 8,
   parameter int  ADDR_W      = 16,
   parameter int  CNT_W       = 16,
   parameter bit  AUTOINIT_EN = 1'b1,
   parameter bit  WORD_EN     = 1'b1,
   localparam int PHYS_W      = PAGE_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PAGE_W-1:0] page,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [CNT_W-1:0]  base_cnt,
   input  logic              autoinit,
   input  logic              word,
   input  logic              mask_set,
   input  logic              mask_clr,
   input  logic              xfer,
   output logic [PHYS_W-1:0] phys,
   output logic [1:0]        lanes,
   output logic              tc
);

   logic [ADDR_W-1:0] cur_addr;

   xag_counter #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .AUTOINIT_EN(AUTOINIT_EN)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .xfer(xfer),
      .mask_set(mask_set), .mask_clr(mask_clr), .autoinit(autoinit),
      .base_addr(base_addr), .base_cnt(base_cnt),
      .cur_addr(cur_addr), .tc(tc)
   );

   xag_map #(
      .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .WORD_EN(WORD_EN)
   ) u_map (
      .page(page), .addr(cur_addr), .word(word),
      .phys(phys), .lanes(lanes)
   );

endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen #(
   parameter int  NCH         = 4,
   parameter int  PAGE_W      = 8,
   parameter int  ADDR_W      = 16,
   parameter int  CNT_W       = 16,
   parameter bit  AUTOINIT_EN = 1'b1,
   parameter bit  WORD_EN     = 1'b1,
   localparam int PHYS_W      = PAGE_W + ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          ch_load,
   input  logic [NCH*PAGE_W-1:0]   ch_page,
   input  logic [NCH*ADDR_W-1:0]   ch_base_addr,
   input  logic [NCH*CNT_W-1:0]    ch_base_cnt,
   input  logic [NCH-1:0]          ch_autoinit,
   input  logic [NCH-1:0]          ch_word,
   input  logic [NCH-1:0]          ch_mask_set,
   input  logic [NCH-1:0]          ch_mask_clr,
   input  logic [NCH-1:0]          ch_xfer,
   output logic [NCH*PHYS_W-1:0]   phys_addr,
   output logic [NCH*2-1:0]        lane_en,
   output logic [NCH-1:0]          tc_pulse
);

   if (NCH < 1) begin : g_bad_nch
      $error("xfer_addr_gen: NCH must be at least 1");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      xag_chan #(
         .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
         .AUTOINIT_EN(AUTOINIT_EN), .WORD_EN(WORD_EN)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (ch_load[c]),
         .page      (ch_page[c*PAGE_W +: PAGE_W]),
         .base_addr (ch_base_addr[c*ADDR_W +: ADDR_W]),
         .base_cnt  (ch_base_cnt[c*CNT_W +: CNT_W]),
         .autoinit  (ch_autoinit[c]),
         .word      (ch_word[c]),
         .mask_set  (ch_mask_set[c]),
         .mask_clr  (ch_mask_clr[c]),
         .xfer      (ch_xfer[c]),
         .phys      (phys_addr[c*PHYS_W +: PHYS_W]),
         .lanes     (lane_en[c*2 +: 2]),
         .tc        (tc_pulse[c])
      );
   end

endmodule

// File: tb/xfer_addr_gen_bench.sv
module xfer_addr_gen_bench;

   localparam int NCH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0]    ld = '0, xf = '0, ms = '0, mc = '0, ai = '0, wd = '0;
   logic [NCH*8-1:0]  pg = '0;
   logic [NCH*16-1:0] ba = '0, bc = '0;
   logic [NCH*24-1:0] phys;
   logic [NCH*2-1:0]  lanes;
   logic [NCH-1:0]    tc;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   xfer_addr_gen #(.NCH(NCH)) u_xfer_addr_gen (
      .clk(clk), .rst_n(rst_n), .ch_load(ld), .ch_page(pg),
      .ch_base_addr(ba), .ch_base_cnt(bc), .ch_autoinit(ai), .ch_word(wd),
      .ch_mask_set(ms), .ch_mask_clr(mc), .ch_xfer(xf),
      .phys_addr(phys), .lane_en(lanes), .tc_pulse(tc)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic setup(input int c, input logic [7:0] p, input logic [15:0] a,
                        input logic [15:0] n, input logic auto, input logic w);
      pg[c*8 +: 8] = p;
      ba[c*16 +: 16] = a;
      bc[c*16 +: 16] = n;
      ai[c] = auto;
      wd[c] = w;
      ld[c] = 1'b1;
      tick();
      ld[c] = 1'b0;
   endtask

   task automatic strobe(input int c);
      xf[c] = 1'b1;
      tick();
      xf[c] = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 phys after reset", 32'(phys), 32'h0);
      chk("R10 tc after reset", 32'(tc), 32'h0);
      xf = '1;
      tick();
      xf = '0;
      chk("R10 R8 masked at reset, strobe ignored", 32'(phys), 32'h0);
      chk("R10 no tc from masked strobes", 32'(tc), 32'h0);
   endtask

   task automatic t_byte_count();
      setup(0, 8'h12, 16'h3456, 16'd3, 1'b0, 1'b0);
      chk("R9 R1 byte load phys", 32'(phys[0 +: 24]), 32'h123456);
      chk("R1 even lane", 32'(lanes[0 +: 2]), 32'h1);
      for (int k = 1; k <= 4; k++) begin
         strobe(0);
         chk("R3 byte step", 32'(phys[0 +: 24]), 32'h123456 + 32'(k));
         chk("R4 R5 tc only on 4th", 32'(tc[0]), (k == 4) ? 32'h1 : 32'h0);
         if (k == 1) chk("R1 odd lane", 32'(lanes[0 +: 2]), 32'h2);
      end
      tick();
      chk("R5 tc one cycle", 32'(tc[0]), 32'h0);
      strobe(0);
      chk("R7 masked after tc, addr held", 32'(phys[0 +: 24]), 32'h12345A);
      chk("R7 no further tc", 32'(tc[0]), 32'h0);
   endtask

   task automatic t_word();
      setup(1, 8'h35, 16'h0004, 16'd10, 1'b0, 1'b1);
      chk("R2 word phys, page bit0 ignored", 32'(phys[24 +: 24]), 32'h340008);
      chk("R2 word lanes", 32'(lanes[2 +: 2]), 32'h3);
      strobe(1);
      chk("R2 R3 word step", 32'(phys[24 +: 24]), 32'h34000A);
      setup(1, 8'h34, 16'hFFFF, 16'd10, 1'b0, 1'b1);
      chk("R2 word top of page", 32'(phys[24 +: 24]), 32'h35FFFE);
      strobe(1);
      chk("R11 word wrap in page", 32'(phys[24 +: 24]), 32'h340000);
   endtask

   task automatic t_byte_wrap_mask();
      setup(2, 8'h7F, 16'hFFFF, 16'd5, 1'b0, 1'b0);
      chk("R1 byte top", 32'(phys[48 +: 24]), 32'h7FFFFF);
      strobe(2);
      chk("R11 byte wrap in page", 32'(phys[48 +: 24]), 32'h7F0000);
      ms[2] = 1'b1;
      tick();
      ms[2] = 1'b0;
      strobe(2);
      chk("R8 mask_set blocks strobe", 32'(phys[48 +: 24]), 32'h7F0000);
      mc[2] = 1'b1;
      tick();
      mc[2] = 1'b0;
      strobe(2);
      chk("R8 mask_clr re-enables", 32'(phys[48 +: 24]), 32'h7F0001);
      ld[2] = 1'b1;
      xf[2] = 1'b1;
      tick();
      ld[2] = 1'b0;
      xf[2] = 1'b0;
      chk("R9 load beats strobe", 32'(phys[48 +: 24]), 32'h7FFFFF);
   endtask

   task automatic t_autoinit();
      setup(3, 8'h01, 16'h0100, 16'd1, 1'b1, 1'b0);
      strobe(3);
      chk("R6 first step", 32'(phys[72 +: 24]), 32'h010101);
      chk("R6 no tc yet", 32'(tc[3]), 32'h0);
      strobe(3);
      chk("R6 tc raised", 32'(tc[3]), 32'h1);
      chk("R6 address reloaded", 32'(phys[72 +: 24]), 32'h010100);
      strobe(3);
      chk("R6 still unmasked", 32'(phys[72 +: 24]), 32'h010101);
      strobe(3);
      chk("R6 count reloaded, tc again", 32'(tc[3]), 32'h1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_byte_count();
      t_word();
      t_byte_wrap_mask();
      t_autoinit();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule